// File: doc/BRIEF.md
# Memory-Operand Micro-Op Cracker

This decode-stage block takes one decoded three-operand arithmetic instruction per input handshake. It turns that instruction into an ordered stream of register-style micro-ops on a valid/ready output port. Each of the two sources is a plain register, a register-deferred memory reference `(rN)`, or a base-plus-displacement memory reference `d(rN)`. The destination is always an architectural register.

A mode input picks one of two target pipelines. In split mode, every memory source becomes a load into a temporary register, and the loads are followed by one register-register arithmetic micro-op. In load-op mode, the last memory source is not loaded separately. The arithmetic micro-op reads that memory reference itself, with its address formed in an address stage ahead of execute. Any earlier memory source is still loaded first.

Temporaries come from a small fixed pool. Numbering restarts at the first temporary for every instruction. The block never holds more than one instruction.

Top module: `uop_cracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: An instruction is captured on a clock edge where `in_valid_i` and `in_ready_o` are both 1. From the next cycle, `in_ready_o` stays 0 and the input pins are ignored until the micro-op with `out_last_o`=1 has been taken. `in_ready_o` returns to 1 in the cycle after that transfer, with `out_valid_o` 0.
- R3: While `out_valid_o` is 1 and `out_ready_i` is 0, the presented micro-op does not change.
- R4: Source kind codes are 00 register, 01 register-deferred and 1x displacement. A deferred source always yields displacement 0, whatever value is on its displacement pins. A displacement source carries its pin value unchanged.
- R5: In split mode (`lop_mode_i`=0), each memory source produces a load micro-op (kind 01) in source-slot order, slot 0 first. Its stage code is 01, meaning the address is formed in EX and accessed in MEM. `out_a_o` is {0, base register}, `out_b_o` is 0, and the destination is a temporary.
- R6: The final micro-op of a split-mode instruction has kind 00 and stage 00. It writes {0, destination}, and its `out_a_o`/`out_b_o` name the temporary loaded for a memory source, or {0, register} for a register source.
- R7: In load-op mode (`lop_mode_i`=1), the highest-numbered memory source is fused. The final micro-op then has kind 10 and stage 10 (AGU before EX). `out_mem_slot_o` gives that slot, the slot's operand field holds {0, base register}, and `out_disp_o` holds its displacement. An earlier memory source is loaded as in R5.
- R8: With two register sources, exactly one micro-op (kind 00, stage 00, displacement 0, last) is emitted in either mode.
- R9: The mode is sampled when the instruction is captured. Changing `lop_mode_i` during the sequence has no effect on it.
- R10: Every micro-op carries the instruction's opcode on `out_op_o`. `out_last_o` is 1 on the final micro-op only.
- R11: A temporary is tagged with bit 5 = 1 and an index in bits 4:0. The first load of every instruction uses index 0 and the second uses index 1. No index reaches the pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lop_mode_i | input | 1 | 0 split loads, 1 fused load-op |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Block can capture an instruction |
| in_op_i | input | OP_W | Arithmetic opcode |
| in_dst_i | input | REG_W | Destination register |
| in_s0_kind_i | input | 2 | Source 0 kind |
| in_s0_reg_i | input | REG_W | Source 0 register or base |
| in_s0_disp_i | input | DISP_W | Source 0 displacement |
| in_s1_kind_i | input | 2 | Source 1 kind |
| in_s1_reg_i | input | REG_W | Source 1 register or base |
| in_s1_disp_i | input | DISP_W | Source 1 displacement |
| out_valid_o | output | 1 | Micro-op valid |
| out_ready_i | input | 1 | Consumer takes the micro-op |
| out_kind_o | output | 2 | 00 ALU, 01 load, 10 fused load-op |
| out_op_o | output | OP_W | Opcode |
| out_dst_o | output | REG_W+1 | Destination tag (MSB set = temporary) |
| out_a_o | output | REG_W+1 | Operand A tag, or load base |
| out_b_o | output | REG_W+1 | Operand B tag |
| out_disp_o | output | DISP_W | Displacement |
| out_mem_slot_o | output | 1 | Fused memory operand slot |
| out_stage_o | output | 2 | 00 none, 01 EX address, 10 AGU address |
| out_last_o | output | 1 | Final micro-op of the instruction |

## Verification
The bench goes after these corner cases:

- **Deferred source with a nonzero displacement on its pins.** A decoder that forwarded the pins would emit a wrong address offset.
- **Only slot 1 in memory, and both slots in memory under load-op mode.** A cracker that fused the first memory source, or numbered temporaries by slot, would leave an operand pointing at the wrong register.
- **Back-to-back instructions.** These expose temporaries that are not restarted at index 0.
- **Stalls on the output, with mode and input pins changed mid-sequence.** A design that advanced without a transfer, re-sampled the mode, or took a second instruction early would drop, repeat or corrupt micro-ops.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int N_SRC  = 2;
  localparam int N_UOP  = N_SRC + 1;
  localparam int CNT_W  = $clog2(N_UOP + 1);
  localparam int SLOT_W = $clog2(N_SRC);

  localparam logic [1:0] SK_REG   = 2'b00;
  localparam logic [1:0] SK_DEFER = 2'b01;

  localparam logic [1:0] UK_ALU   = 2'b00;
  localparam logic [1:0] UK_LOAD  = 2'b01;
  localparam logic [1:0] UK_FUSED = 2'b10;

  localparam logic [1:0] ST_NONE  = 2'b00;
  localparam logic [1:0] ST_EX    = 2'b01;
  localparam logic [1:0] ST_AGU   = 2'b10;
endpackage

// File: rtl/uc_src_norm.sv
module uc_src_norm
  import uc_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic [1:0]        kind_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              is_mem_o,
  output logic [REG_W:0]    tag_o,
  output logic [DISP_W-1:0] disp_o
);
  assign is_mem_o = (kind_i != SK_REG);
  assign tag_o    = {1'b0, reg_i};
  // deferred form is displacement form with offset zero
  assign disp_o   = (kind_i == SK_DEFER) ? '0 : disp_i;
endmodule

// File: rtl/uc_planner.sv
module uc_planner
  import uc_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic              lop_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              is_mem_i [N_SRC],
  input  logic [REG_W:0]    base_i   [N_SRC],
  input  logic [DISP_W-1:0] disp_i   [N_SRC],
  output logic [1:0]        kind_o   [N_UOP],
  output logic [REG_W:0]    dst_o    [N_UOP],
  output logic [REG_W:0]    a_o      [N_UOP],
  output logic [REG_W:0]    b_o      [N_UOP],
  output logic [DISP_W-1:0] disp_o   [N_UOP],
  output logic [SLOT_W-1:0] slot_o   [N_UOP],
  output logic [1:0]        stage_o  [N_UOP],
  output logic [CNT_W-1:0]  cnt_o
);
  logic              fuse_v;
  logic [SLOT_W-1:0] fuse_idx;
  logic [REG_W:0]    tag [N_SRC];
  logic [CNT_W-1:0]  n;

  always_comb begin
    fuse_v   = 1'b0;
    fuse_idx = '0;
    if (lop_i) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (is_mem_i[s]) begin
          fuse_v   = 1'b1;
          fuse_idx = SLOT_W'(s);
        end
      end
    end

    for (int u = 0; u < N_UOP; u++) begin
      kind_o[u]  = UK_ALU;
      dst_o[u]   = '0;
      a_o[u]     = '0;
      b_o[u]     = '0;
      disp_o[u]  = '0;
      slot_o[u]  = '0;
      stage_o[u] = ST_NONE;
    end

    n = '0;
    for (int s = 0; s < N_SRC; s++) begin
      tag[s] = base_i[s];
      if (is_mem_i[s] && !(fuse_v && fuse_idx == SLOT_W'(s))) begin
        kind_o[n]  = UK_LOAD;
        dst_o[n]   = {1'b1, REG_W'(n)};  // temp index = loads so far
        a_o[n]     = base_i[s];
        disp_o[n]  = disp_i[s];
        stage_o[n] = ST_EX;
        tag[s]     = {1'b1, REG_W'(n)};
        n          = n + CNT_W'(1);
      end
    end

    kind_o[n]  = fuse_v ? UK_FUSED : UK_ALU;
    dst_o[n]   = {1'b0, dst_i};
    a_o[n]     = tag[0];
    b_o[n]     = tag[1];
    disp_o[n]  = fuse_v ? disp_i[fuse_idx] : '0;
    slot_o[n]  = fuse_v ? fuse_idx : '0;
    stage_o[n] = fuse_v ? ST_AGU : ST_NONE;
    cnt_o      = n + CNT_W'(1);
  end
endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
  import uc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             out_ready_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             out_valid_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             accept_o
);
  logic             busy_q;
  logic [CNT_W-1:0] idx_q;

  assign in_ready_o  = !busy_q;
  assign out_valid_o = busy_q;
  assign accept_o    = in_valid_i && !busy_q;
  assign idx_o       = idx_q;
  assign last_o      = (idx_q == cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && out_ready_i) begin
      if (last_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + CNT_W'(1);
      end
    end
  end

  assert_busy_blocks_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_stall_holds_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(idx_q));

  assert_sequence_continues_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !last_o |=> out_valid_o && idx_q == $past(idx_q) + CNT_W'(1));

  assert_index_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> idx_q < cnt_i);
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uc_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int REG_W  = 5,
  parameter int DISP_W = 16,
  parameter int TMP_N  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lop_mode_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [OP_W-1:0]     in_op_i,
  input  logic [REG_W-1:0]    in_dst_i,
  input  logic [1:0]          in_s0_kind_i,
  input  logic [REG_W-1:0]    in_s0_reg_i,
  input  logic [DISP_W-1:0]   in_s0_disp_i,
  input  logic [1:0]          in_s1_kind_i,
  input  logic [REG_W-1:0]    in_s1_reg_i,
  input  logic [DISP_W-1:0]   in_s1_disp_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [1:0]          out_kind_o,
  output logic [OP_W-1:0]     out_op_o,
  output logic [REG_W:0]      out_dst_o,
  output logic [REG_W:0]      out_a_o,
  output logic [REG_W:0]      out_b_o,
  output logic [DISP_W-1:0]   out_disp_o,
  output logic [SLOT_W-1:0]   out_mem_slot_o,
  output logic [1:0]          out_stage_o,
  output logic                out_last_o
);
  logic [1:0]        kind_in [N_SRC];
  logic [REG_W-1:0]  reg_in  [N_SRC];
  logic [DISP_W-1:0] disp_in [N_SRC];

  assign kind_in[0] = in_s0_kind_i;
  assign kind_in[1] = in_s1_kind_i;
  assign reg_in[0]  = in_s0_reg_i;
  assign reg_in[1]  = in_s1_reg_i;
  assign disp_in[0] = in_s0_disp_i;
  assign disp_in[1] = in_s1_disp_i;

  logic              accept;
  logic              lop_q;
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  dst_q;
  logic [1:0]        kind_q [N_SRC];
  logic [REG_W-1:0]  reg_q  [N_SRC];
  logic [DISP_W-1:0] disp_q [N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lop_q <= 1'b0;
      op_q  <= '0;
      dst_q <= '0;
      for (int s = 0; s < N_SRC; s++) begin
        kind_q[s] <= SK_REG;
        reg_q[s]  <= '0;
        disp_q[s] <= '0;
      end
    end else if (accept) begin
      lop_q <= lop_mode_i;
      op_q  <= in_op_i;
      dst_q <= in_dst_i;
      for (int s = 0; s < N_SRC; s++) begin
        kind_q[s] <= kind_in[s];
        reg_q[s]  <= reg_in[s];
        disp_q[s] <= disp_in[s];
      end
    end
  end

  logic              is_mem [N_SRC];
  logic [REG_W:0]    base   [N_SRC];
  logic [DISP_W-1:0] edisp  [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    uc_src_norm #(.REG_W(REG_W), .DISP_W(DISP_W)) u_norm (
      .kind_i  (kind_q[s]),
      .reg_i   (reg_q[s]),
      .disp_i  (disp_q[s]),
      .is_mem_o(is_mem[s]),
      .tag_o   (base[s]),
      .disp_o  (edisp[s])
    );
  end

  logic [1:0]        p_kind  [N_UOP];
  logic [REG_W:0]    p_dst   [N_UOP];
  logic [REG_W:0]    p_a     [N_UOP];
  logic [REG_W:0]    p_b     [N_UOP];
  logic [DISP_W-1:0] p_disp  [N_UOP];
  logic [SLOT_W-1:0] p_slot  [N_UOP];
  logic [1:0]        p_stage [N_UOP];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  idx;

  uc_planner #(.REG_W(REG_W), .DISP_W(DISP_W)) u_plan (
    .lop_i   (lop_q),
    .dst_i   (dst_q),
    .is_mem_i(is_mem),
    .base_i  (base),
    .disp_i  (edisp),
    .kind_o  (p_kind),
    .dst_o   (p_dst),
    .a_o     (p_a),
    .b_o     (p_b),
    .disp_o  (p_disp),
    .slot_o  (p_slot),
    .stage_o (p_stage),
    .cnt_o   (cnt)
  );

  uc_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .out_ready_i(out_ready_i),
    .cnt_i      (cnt),
    .out_valid_o(out_valid_o),
    .idx_o      (idx),
    .last_o     (out_last_o),
    .accept_o   (accept)
  );

  assign out_kind_o     = p_kind[idx];
  assign out_op_o       = op_q;
  assign out_dst_o      = p_dst[idx];
  assign out_a_o        = p_a[idx];
  assign out_b_o        = p_b[idx];
  assign out_disp_o     = p_disp[idx];
  assign out_mem_slot_o = p_slot[idx];
  assign out_stage_o    = p_stage[idx];

  assert_mode_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> $stable(lop_q));

  assert_uop_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_kind_o) && $stable(out_dst_o)
      && $stable(out_a_o) && $stable(out_b_o) && $stable(out_disp_o));

  assert_load_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == UK_LOAD |-> out_stage_o == ST_EX && !out_last_o
      && out_dst_o[REG_W] && !out_a_o[REG_W]);

  assert_temp_in_pool_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == UK_LOAD |-> int'(out_dst_o[REG_W-1:0]) < TMP_N);

  assert_alu_final_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == UK_ALU |-> out_last_o && out_stage_o == ST_NONE
      && !out_dst_o[REG_W]);

  assert_fused_agu_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == UK_FUSED |-> lop_q && out_last_o && out_stage_o == ST_AGU);
endmodule

// File: tb/uop_cracker_test.sv
module uop_cracker_test;
  localparam int OP_W = 4, REG_W = 5, DISP_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, lop_mode, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [OP_W-1:0] in_op, out_op;
  logic [REG_W-1:0] in_dst, s0_reg, s1_reg;
  logic [1:0] s0_kind, s1_kind, out_kind, out_stage;
  logic [DISP_W-1:0] s0_disp, s1_disp, out_disp;
  logic [REG_W:0] out_dst, out_a, out_b;
  logic [0:0] out_slot;

  uop_cracker uut (
    .clk_i(clk), .rst_ni(rst_n), .lop_mode_i(lop_mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_dst_i(in_dst),
    .in_s0_kind_i(s0_kind), .in_s0_reg_i(s0_reg), .in_s0_disp_i(s0_disp),
    .in_s1_kind_i(s1_kind), .in_s1_reg_i(s1_reg), .in_s1_disp_i(s1_disp),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_kind_o(out_kind), .out_op_o(out_op), .out_dst_o(out_dst),
    .out_a_o(out_a), .out_b_o(out_b), .out_disp_o(out_disp),
    .out_mem_slot_o(out_slot), .out_stage_o(out_stage), .out_last_o(out_last)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {mode, k0, k1, n, kinds(u2,u1,u0)}
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'b10, 2'd3, 6'b000101},
    {1'b1, 2'b01, 2'b10, 2'd2, 6'b001001},
    {1'b0, 2'b00, 2'b00, 2'd1, 6'b000000},
    {1'b1, 2'b00, 2'b00, 2'd1, 6'b000000},
    {1'b0, 2'b10, 2'b00, 2'd2, 6'b000001},
    {1'b1, 2'b10, 2'b00, 2'd1, 6'b000010},
    {1'b0, 2'b00, 2'b01, 2'd2, 6'b000001},
    {1'b1, 2'b10, 2'b11, 2'd2, 6'b001001},
    {1'b1, 2'b00, 2'b01, 2'd1, 6'b000010}
  };

  logic [REG_W:0] e_dst [3], e_a [3], e_b [3];
  logic [DISP_W-1:0] e_disp [3];
  logic [1:0] e_stage [3];
  logic e_slot [3];

  task automatic model(bit mode, logic [REG_W-1:0] dst,
                       logic [1:0] k0, logic [REG_W-1:0] r0, logic [DISP_W-1:0] d0,
                       logic [1:0] k1, logic [REG_W-1:0] r1, logic [DISP_W-1:0] d1);
    logic [1:0] k [2];
    logic [REG_W-1:0] r [2];
    logic [DISP_W-1:0] d [2];
    logic [REG_W:0] t [2];
    int fuse = -1;
    int n = 0;
    k[0] = k0; k[1] = k1; r[0] = r0; r[1] = r1;
    d[0] = (k0 == 2'b01) ? '0 : d0;
    d[1] = (k1 == 2'b01) ? '0 : d1;
    if (mode) begin
      if (k1 != 0) fuse = 1; else if (k0 != 0) fuse = 0;
    end
    for (int s = 0; s < 2; s++) begin
      t[s] = {1'b0, r[s]};
      if (k[s] != 0 && fuse != s) begin
        e_dst[n] = {1'b1, REG_W'(n)}; e_a[n] = {1'b0, r[s]}; e_b[n] = '0;
        e_disp[n] = d[s]; e_stage[n] = 2'b01; e_slot[n] = 1'b0;
        t[s] = {1'b1, REG_W'(n)};
        n++;
      end
    end
    e_dst[n] = {1'b0, dst}; e_a[n] = t[0]; e_b[n] = t[1];
    e_disp[n] = (fuse >= 0) ? d[fuse] : '0;
    e_stage[n] = (fuse >= 0) ? 2'b10 : 2'b00;
    e_slot[n] = (fuse == 1);
  endtask

  task automatic check_uop(int i, int n, logic [5:0] kinds, logic [OP_W-1:0] op);
    logic [1:0] ek = kinds[2*i +: 2];
    string rq = (ek == 2'b01) ? "R5/R9" : (ek == 2'b10) ? "R7/R9" : (n == 1) ? "R8" : "R6";
    chk("R2", $sformatf("uop%0d valid", i), out_valid, 1);
    chk(rq, $sformatf("uop%0d kind", i), out_kind, ek);
    chk(ek == 2'b01 ? "R11" : rq, $sformatf("uop%0d dst", i), out_dst, e_dst[i]);
    chk(rq, $sformatf("uop%0d a", i), out_a, e_a[i]);
    chk(rq, $sformatf("uop%0d b", i), out_b, e_b[i]);
    chk("R4", $sformatf("uop%0d disp", i), out_disp, e_disp[i]);
    chk(rq, $sformatf("uop%0d stage", i), out_stage, e_stage[i]);
    if (ek == 2'b10) chk("R7", "fused slot", out_slot, e_slot[i]);
    chk("R10", $sformatf("uop%0d op", i), out_op, op);
    chk("R10", $sformatf("uop%0d last", i), out_last, (i == n - 1));
  endtask

  task automatic run(bit mode, logic [OP_W-1:0] op, logic [REG_W-1:0] dst,
                     logic [1:0] k0, logic [REG_W-1:0] r0, logic [DISP_W-1:0] d0,
                     logic [1:0] k1, logic [REG_W-1:0] r1, logic [DISP_W-1:0] d1,
                     int n, logic [5:0] kinds, int stall);
    model(mode, dst, k0, r0, d0, k1, r1, d1);
    @(negedge clk);
    chk("R2", "ready before issue", in_ready, 1);
    lop_mode = mode; in_valid = 1'b1; in_op = op; in_dst = dst;
    s0_kind = k0; s0_reg = r0; s0_disp = d0;
    s1_kind = k1; s1_reg = r1; s1_disp = d1;
    @(negedge clk);
    // disturb mode and pins while busy
    lop_mode = ~mode; in_op = ~op; in_dst = ~dst;
    s0_kind = ~k0; s0_reg = ~r0; s0_disp = ~d0;
    s1_kind = ~k1; s1_reg = ~r1; s1_disp = ~d1;
    chk("R2", "ready low while busy", in_ready, 0);
    for (int i = 0; i < n; i++) begin
      if (stall > 0) begin
        out_ready = 1'b0;
        for (int j = 0; j < stall; j++) begin
          check_uop(i, n, kinds, op);
          @(negedge clk);
        end
        out_ready = 1'b1;
      end
      check_uop(i, n, kinds, op);
      if (stall > 0) chk("R3", "held uop kind after stall", out_kind, kinds[2*i +: 2]);
      @(negedge clk);
    end
    chk("R2", "ready after last", in_ready, 1);
    chk("R2", "valid after last", out_valid, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; lop_mode = 0; in_valid = 0; out_ready = 1; in_op = 0; in_dst = 0;
    s0_kind = 0; s0_reg = 0; s0_disp = 0; s1_kind = 0; s1_reg = 0; s1_disp = 0;
    repeat (2) @(negedge clk);
    chk("R1", "ready in reset", in_ready, 1);
    chk("R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", in_ready, 1);
    chk("R1", "valid after reset", out_valid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] e = VEC[v];
      run(e[12], OP_W'(v + 3), REG_W'(9 + v), e[11:10], REG_W'(2 + v), DISP_W'(16'h40 + v),
          e[9:8], REG_W'(3 + 2 * v), DISP_W'(8 * (v + 1)), int'(e[7:6]), e[5:0], 0);
    end

    // R3: stalls on the worked example, split form
    run(1'b0, 4'h1, 5'd9, 2'b01, 5'd2, 16'h1234, 2'b10, 5'd3, 16'd8, 3, 6'b000101, 2);
    // R3/R7: stalls in load-op form, both memory
    run(1'b1, 4'h2, 5'd7, 2'b10, 5'd4, 16'hfff0, 2'b10, 5'd5, 16'h0020, 2, 6'b001001, 3);
    // R11: back-to-back, temps restart at index 0
    run(1'b0, 4'h6, 5'd1, 2'b10, 5'd30, 16'h7, 2'b11, 5'd31, 16'h9, 3, 6'b000101, 0);
    run(1'b0, 4'h7, 5'd2, 2'b00, 5'd12, 16'h0, 2'b10, 5'd13, 16'h5, 2, 6'b000001, 0);
    // R4: deferred with all-ones displacement pins, fused
    run(1'b1, 4'h8, 5'd3, 2'b00, 5'd1, 16'hffff, 2'b01, 5'd6, 16'hffff, 1, 6'b000010, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule